// File: doc/BRIEF.md
# Key-Guarded System Control Register Bank

This block is a bank of system status and control registers inside a 4 KB window on a plain 32-bit register bus. The bus has an address, a write strobe with write data, a read strobe, and a read data return. It holds a board identity word fixed at build time, an LED register that also drives output pins, and two general configuration words. It also holds two flag words, one volatile and one meant to persist. Each flag word has one address that sets bits and another that clears bits. A reset-control word drives a system reset request.

The reset-control word is protected by a key register. Software must first write the 16-bit unlock key into the key register. Only then does a write to reset control take effect. Any other value written to the key register is stored with bit 15 forced low, which leaves the bank locked. An accepted reset-control write that has the trigger bit set produces a one-cycle request pulse. Several offsets return fixed constants. Accesses to offsets that the bank does not decode read zero, change nothing, and set a sticky error flag.

The bus has no back-pressure. Every access completes in the cycle it is presented. Read data is combinational from the address, and writes take effect on the next clock edge. The block only requests a reset; it does not reset itself. The persistent flags are cleared only by the power-on reset input.

Top module: `sysreg_bank`

## Requirements
- R1: After power-on reset: the flag word (0x30) reads 3. The key (0x20), reset-control (0x40), persistent-flag (0x38), LED (0x08) and config words read 0. `reset_req` and `decode_err` are 0.
- R2: Key register (0x20): writing exactly 0x0000A05F stores 0xA05F. Any other write stores bits 14:0 of the data. The register reads back zero-extended, so bit 15 and above read 0.
- R3: A write to reset control (0x40) is accepted only while the key register equals 0xA05F. Otherwise the write is ignored and 0x40 keeps its old value.
- R4: An accepted reset-control write with bit 8 set drives `reset_req` high for exactly the one cycle after the write edge. The written word reads back at 0x40. An accepted write with bit 8 clear, and any ignored write, produce no pulse.
- R5: Volatile flags read at 0x30. A write to 0x30 ORs the data into the flags. A write to 0x34 clears the flag bits that are 1 in the data. Reading 0x34 returns 0.
- R6: Persistent flags read at 0x38. They follow the same OR rule at 0x38 and the same clear rule at 0x3C.
- R7: Offset 0x00 returns the `ID_VALUE` parameter, and writes to it are ignored.
- R8: The following offsets return fixed values:

  | Offset | Value |
  |---|---|
  | 0x44 | 1 |
  | 0x50 | 0x1000 |
  | 0x84 | 0x02000000 |
  | 0x88 | 0xFF000000 |
  | 0x04, 0x1C and the other decoded-unimplemented offsets | 0 |

- R9: The LED word (0x08) and the config words (0x28, 0x2C) are full 32-bit read/write registers. `led_out` equals the LED word.
- R10: A read or write at an undecoded offset returns 0 and modifies no register. Undecoded offsets include any address with bits 1:0 nonzero and any offset above 0xD0. Such an access sets `decode_err` on the next edge, and `decode_err` stays set until power-on reset.
- R11: `rd_data` reflects the current address within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| addr | input | 12 | Byte offset in the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (used for decode-error tracking) |
| rd_data | output | 32 | Combinational read data |
| led_out | output | 32 | LED register contents |
| reset_req | output | 1 | One-cycle system reset request |
| decode_err | output | 1 | Sticky undecoded-access flag |

## Verification
A wrong key register becomes visible in two ways at the next read of 0x20. A second symptom appears one cycle after a reset-control write: either a missing or extra `reset_req` pulse, or a changed readback at 0x40. A corrupted flag word shows at the next read of 0x30 or 0x38, right after the set or clear write. A decoder that slips shows up in the same cycle as a nonzero read, or as a changed register after an undecoded write. A missed error capture shows on `decode_err` one edge after the access.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int WIN_AW = 12;

  localparam logic [WIN_AW-1:0] OFS_ID     = 12'h000;
  localparam logic [WIN_AW-1:0] OFS_LED    = 12'h008;
  localparam logic [WIN_AW-1:0] OFS_KEY    = 12'h020;
  localparam logic [WIN_AW-1:0] OFS_CFGA   = 12'h028;
  localparam logic [WIN_AW-1:0] OFS_CFGB   = 12'h02C;
  localparam logic [WIN_AW-1:0] OFS_FSET   = 12'h030;
  localparam logic [WIN_AW-1:0] OFS_FCLR   = 12'h034;
  localparam logic [WIN_AW-1:0] OFS_NSET   = 12'h038;
  localparam logic [WIN_AW-1:0] OFS_NCLR   = 12'h03C;
  localparam logic [WIN_AW-1:0] OFS_RCTL   = 12'h040;
  localparam logic [WIN_AW-1:0] OFS_K44    = 12'h044;
  localparam logic [WIN_AW-1:0] OFS_K50    = 12'h050;
  localparam logic [WIN_AW-1:0] OFS_K84    = 12'h084;
  localparam logic [WIN_AW-1:0] OFS_K88    = 12'h088;

  localparam logic [31:0] CONST_K44 = 32'h0000_0001;
  localparam logic [31:0] CONST_K50 = 32'h0000_1000;
  localparam logic [31:0] CONST_K84 = 32'h0200_0000;
  localparam logic [31:0] CONST_K88 = 32'hFF00_0000;

  typedef enum logic [3:0] {
    SEL_ID, SEL_LED, SEL_KEY, SEL_CFGA, SEL_CFGB,
    SEL_FSET, SEL_FCLR, SEL_NSET, SEL_NCLR, SEL_RCTL,
    SEL_K44, SEL_K50, SEL_K84, SEL_K88, SEL_ZERO, SEL_NONE
  } sel_e;
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
(
  input  logic [WIN_AW-1:0] addr,
  output sel_e              sel
);
  always_comb begin
    case (addr)
      OFS_ID:   sel = SEL_ID;
      OFS_LED:  sel = SEL_LED;
      OFS_KEY:  sel = SEL_KEY;
      OFS_CFGA: sel = SEL_CFGA;
      OFS_CFGB: sel = SEL_CFGB;
      OFS_FSET: sel = SEL_FSET;
      OFS_FCLR: sel = SEL_FCLR;
      OFS_NSET: sel = SEL_NSET;
      OFS_NCLR: sel = SEL_NCLR;
      OFS_RCTL: sel = SEL_RCTL;
      OFS_K44:  sel = SEL_K44;
      OFS_K50:  sel = SEL_K50;
      OFS_K84:  sel = SEL_K84;
      OFS_K88:  sel = SEL_K88;
      12'h004, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C, 12'h024,
      12'h048, 12'h04C, 12'h054, 12'h058, 12'h05C, 12'h060,
      12'h064, 12'h068, 12'h06C, 12'h070, 12'h074, 12'h080,
      12'h08C, 12'h090, 12'h094, 12'h098, 12'h09C,
      12'h0C0, 12'h0C4, 12'h0C8, 12'h0CC, 12'h0D0:
                sel = SEL_ZERO;
      default:  sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/sysreg_setclr.sv
module sysreg_setclr #(
  parameter int              W   = 32,
  parameter logic [W-1:0]    RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RST;
    else if (set_en) q <= q | wdata;
    else if (clr_en) q <= q & ~wdata;
  end

  // R5 / R6: set alias leaves every written one bit high
  a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(wdata)) == $past(wdata)));
  // R5 / R6: clear alias leaves every written one bit low
  a_r5_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((q & $past(wdata)) == '0));
  // R6: no access, no change
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(q));
endmodule

// File: rtl/sysreg_guard.sv
module sysreg_guard #(
  parameter int                 DATA_W    = 32,
  parameter int                 KEY_W     = 16,
  parameter logic [KEY_W-1:0]   KEY       = 16'hA05F,
  parameter int                 TRIG_BIT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic              rctl_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [KEY_W-1:0]  key_q,
  output logic [DATA_W-1:0] rctl_q,
  output logic              reset_req
);
  localparam logic [DATA_W-1:0] KEY_FULL = DATA_W'(KEY);

  logic unlocked;
  logic accept;
  assign unlocked = (key_q == KEY);
  assign accept   = rctl_we && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q     <= '0;
      rctl_q    <= '0;
      reset_req <= 1'b0;
    end else begin
      if (key_we)
        key_q <= (wdata == KEY_FULL) ? KEY : {1'b0, wdata[KEY_W-2:0]};
      if (accept)
        rctl_q <= wdata;
      reset_req <= accept && wdata[TRIG_BIT];
    end
  end

  // R2: a set top bit only ever comes with the full key
  a_r2_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    key_q[KEY_W-1] |-> (key_q == KEY));
  // R3: locked writes leave reset control untouched
  a_r3_locked_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (rctl_we && !unlocked) |=> $stable(rctl_q));
  // R4: every pulse has an accepted triggering write behind it
  a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(rctl_we && unlocked && wdata[TRIG_BIT]));
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int                 DATA_W    = 32,
  parameter logic [DATA_W-1:0]  ID_VALUE  = 32'h4170_0500,
  parameter logic [DATA_W-1:0]  FLAGS_RST = 32'h0000_0003,
  parameter logic [DATA_W-1:0]  NV_RST    = 32'h0000_0000,
  parameter int                 KEY_W     = 16,
  parameter logic [KEY_W-1:0]   KEY       = 16'hA05F,
  parameter int                 TRIG_BIT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_AW-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] led_out,
  output logic              reset_req,
  output logic              decode_err
);
  sel_e              sel;
  logic [DATA_W-1:0] led_q, cfga_q, cfgb_q, flags_q, nv_q, rctl_q;
  logic [KEY_W-1:0]  key_q;
  logic              err_q;

  sysreg_decode u_decode (.addr(addr), .sel(sel));

  sysreg_setclr #(.W(DATA_W), .RST(FLAGS_RST)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_en && sel == SEL_FSET), .clr_en(wr_en && sel == SEL_FCLR),
    .wdata(wr_data), .q(flags_q));

  sysreg_setclr #(.W(DATA_W), .RST(NV_RST)) u_nvflags (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_en && sel == SEL_NSET), .clr_en(wr_en && sel == SEL_NCLR),
    .wdata(wr_data), .q(nv_q));

  sysreg_guard #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY),
                 .TRIG_BIT(TRIG_BIT)) u_guard (
    .clk(clk), .rst_n(rst_n),
    .key_we(wr_en && sel == SEL_KEY), .rctl_we(wr_en && sel == SEL_RCTL),
    .wdata(wr_data), .key_q(key_q), .rctl_q(rctl_q), .reset_req(reset_req));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q  <= '0;
      cfga_q <= '0;
      cfgb_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_LED)  led_q  <= wr_data;
      if (wr_en && sel == SEL_CFGA) cfga_q <= wr_data;
      if (wr_en && sel == SEL_CFGB) cfgb_q <= wr_data;
      if ((wr_en || rd_en) && sel == SEL_NONE) err_q <= 1'b1;
    end
  end

  always_comb begin
    case (sel)
      SEL_ID:   rd_data = ID_VALUE;
      SEL_LED:  rd_data = led_q;
      SEL_KEY:  rd_data = DATA_W'(key_q);
      SEL_CFGA: rd_data = cfga_q;
      SEL_CFGB: rd_data = cfgb_q;
      SEL_FSET: rd_data = flags_q;
      SEL_NSET: rd_data = nv_q;
      SEL_RCTL: rd_data = rctl_q;
      SEL_K44:  rd_data = DATA_W'(CONST_K44);
      SEL_K50:  rd_data = DATA_W'(CONST_K50);
      SEL_K84:  rd_data = DATA_W'(CONST_K84);
      SEL_K88:  rd_data = DATA_W'(CONST_K88);
      default:  rd_data = '0;
    endcase
  end

  assign led_out    = led_q;
  assign decode_err = err_q;

  // R10: the error flag never drops once raised
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R10: undecoded writes modify no plain register
  a_r10_no_side: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_NONE) |=> ($stable(led_q) && $stable(cfga_q) &&
                                    $stable(cfgb_q) && $stable(rctl_q)));
  // R9: plain registers change only through their own offset
  a_r9_led_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_LED) |=> $stable(led_q));
endmodule

// File: tb/sysreg_bank_bench.sv
module sysreg_bank_bench;
  localparam logic [31:0] ID = 32'h1357_9BDF;
  localparam int NV = 24;
  // {write, offset, data-or-expected}
  localparam logic [44:0] VEC [0:NV-1] = '{
    {1'b1, 12'h008, 32'h0000_005A},  // R9
    {1'b0, 12'h008, 32'h0000_005A},  // R9
    {1'b1, 12'h028, 32'hDEAD_BEEF},  // R9
    {1'b0, 12'h028, 32'hDEAD_BEEF},  // R9
    {1'b1, 12'h02C, 32'h1234_5678},  // R9
    {1'b0, 12'h02C, 32'h1234_5678},  // R9
    {1'b0, 12'h030, 32'h0000_0003},  // R5
    {1'b1, 12'h030, 32'h0000_00F0},  // R5
    {1'b0, 12'h030, 32'h0000_00F3},  // R5
    {1'b1, 12'h034, 32'h0000_0011},  // R5
    {1'b0, 12'h030, 32'h0000_00E2},  // R5
    {1'b1, 12'h038, 32'h0000_0F0F},  // R6
    {1'b0, 12'h038, 32'h0000_0F0F},  // R6
    {1'b1, 12'h03C, 32'h0000_0003},  // R6
    {1'b0, 12'h038, 32'h0000_0F0C},  // R6
    {1'b0, 12'h044, 32'h0000_0001},  // R8
    {1'b0, 12'h050, 32'h0000_1000},  // R8
    {1'b0, 12'h084, 32'h0200_0000},  // R8
    {1'b0, 12'h088, 32'hFF00_0000},  // R8
    {1'b1, 12'h000, 32'hFFFF_FFFF},  // R7
    {1'b0, 12'h000, ID},             // R7
    {1'b0, 12'h004, 32'h0000_0000},  // R8
    {1'b0, 12'h01C, 32'h0000_0000},  // R8
    {1'b0, 12'h034, 32'h0000_0000}   // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data, led_out;
  logic        reset_req, decode_err;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sysreg_bank #(.ID_VALUE(ID)) u_sysreg_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .led_out(led_out),
    .reset_req(reset_req), .decode_err(decode_err));

  always @(posedge clk) if (rst_n && reset_req) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 flags", 12'h030, 32'h3);
    rd_chk("R1 key", 12'h020, 32'h0);
    rd_chk("R1 rctl", 12'h040, 32'h0);
    rd_chk("R1 nvflags", 12'h038, 32'h0);
    rd_chk("R1 led", 12'h008, 32'h0);
    rd_chk("R1 cfg", 12'h028, 32'h0);
    check("R1 reset_req", {31'b0, reset_req}, 32'h0);
    check("R1 decode_err", {31'b0, decode_err}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) wr(VEC[i][43:32], VEC[i][31:0]);
      else rd_chk($sformatf("vector %0d (R5..R9)", i), VEC[i][43:32], VEC[i][31:0]);
    end
    check("R9 led_out", led_out, 32'h5A);

    // R11 combinational read, two addresses within one low phase
    @(negedge clk);
    addr = 12'h044; #1 check("R11 first", rd_data, 32'h1);
    addr = 12'h050; #1 check("R11 second", rd_data, 32'h1000);

    // R2 key register forms
    wr(12'h020, 32'h1234_FFFF);
    rd_chk("R2 masked", 12'h020, 32'h0000_7FFF);
    wr(12'h020, 32'h0001_A05F);
    rd_chk("R2 near key", 12'h020, 32'h0000_205F);

    // R3 locked write ignored
    wr(12'h040, 32'h0000_01FF);
    rd_chk("R3 locked", 12'h040, 32'h0);

    wr(12'h020, 32'h0000_A05F);
    rd_chk("R2 key stored", 12'h020, 32'h0000_A05F);
    wr(12'h040, 32'h0000_00FF);
    rd_chk("R3 accepted", 12'h040, 32'h0000_00FF);
    check("R4 no pulse yet", pulses, 0);

    // R4 trigger pulse: high the cycle after the edge, low the next
    wr(12'h040, 32'h0000_01A5);
    @(negedge clk);
    check("R4 pulse high", {31'b0, reset_req}, 32'h1);
    @(negedge clk);
    check("R4 pulse low", {31'b0, reset_req}, 32'h0);
    rd_chk("R4 readback", 12'h040, 32'h0000_01A5);

    wr(12'h020, 32'h0);
    wr(12'h040, 32'h0000_0100);
    rd_chk("R3 relocked", 12'h040, 32'h0000_01A5);
    check("R4 pulse count", pulses, 1);

    // R10 undecoded accesses
    check("R10 clean", {31'b0, decode_err}, 32'h0);
    wr(12'h0E0, 32'hFFFF_FFFF);
    wr(12'h009, 32'hFFFF_FFFF);
    wr(12'h031, 32'hFFFF_FFFF);
    check("R10 err set", {31'b0, decode_err}, 32'h1);
    rd_chk("R10 flags kept", 12'h030, 32'hE2);
    rd_chk("R10 led kept", 12'h008, 32'h5A);
    rd_chk("R10 read zero", 12'h104, 32'h0);
    rd_chk("R10 misaligned zero", 12'h02A, 32'h0);
    rd_chk("R10 sticky", 12'h000, ID);
    check("R10 still set", {31'b0, decode_err}, 32'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule